// File: doc/BRIEF.md
# Three-State PWM Input Qualifier

This block turns a controller's PWM line into one of three clean commands for a power-stage gate sequencer: drive the high side, drive the low side, or shut both off. An analog front end compares the line against four thresholds and hands over four digital flags. Two of the flags mark the logic levels. The other two mark the edges of a mid-level window that sits between those levels. The high logic threshold lies a little above the upper window edge, and the low logic threshold lies a little below the lower window edge. This leaves a narrow hysteresis band at each side of the window.

The flags are first resynchronized into the system clock domain and then classified into a zone: high, low, window or band. A high or low zone sets the command straight away. A window zone must persist for a programmable number of consecutive clock cycles before the command falls to shut-off. This lets a controller park the line at mid-level (an open input floats into the window) to shed a phase, while ignoring fast edges that only pass through the window. A band zone keeps whatever command was last issued. Leaving shut-off needs no extra qualification: the next high or low zone takes effect with the normal latency.

Top module: `pwm_tristate_qualifier`

## Requirements
- R1: The output `cmd` is encoded as 2'b00 = shut-off, 2'b01 = drive-low, 2'b10 = drive-high. A synchronous reset forces 2'b00. After reset the output stays 2'b00 until a high or low zone is seen, and band inputs do not change it.
- R2: When `above_high` is 1, `cmd` becomes 2'b10 after the third rising clock edge following the input change. Two edges are spent in the synchronizer and one in the output register.
- R3: When `below_low` is 1 and `above_high` is 0, `cmd` becomes 2'b01 with the same three-edge latency.
- R4: When `above_win_top` and `below_win_bot` are both 0 (window zone, which includes a floating input), `cmd` becomes 2'b00 only after the window zone has been seen for HOLD_CYCLES consecutive cycles. The change appears at edge HOLD_CYCLES+2 after the input entered the window, and not before.
- R5: If the input leaves the window before the hold-off count expires, the count restarts from zero. A window lasting HOLD_CYCLES-1 cycles, then a one-cycle excursion, then another HOLD_CYCLES-1 cycles never produces shut-off.
- R6: In a band zone (`above_win_top`=1 with `above_high`=0, or `below_win_bot`=1 with `below_low`=0), `cmd` keeps its previous value indefinitely.
- R7: From shut-off, a high zone gives 2'b10 and a low zone gives 2'b01 with the same three-edge latency as R2/R3, with no extra delay.
- R8: Contradictory flag sets resolve by priority. `above_high` wins over everything. `below_low` wins over the window flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| above_high | input | 1 | Line above the high logic threshold |
| above_win_top | input | 1 | Line above the upper window edge |
| below_win_bot | input | 1 | Line below the lower window edge |
| below_low | input | 1 | Line below the low logic threshold |
| cmd | output | 2 | Qualified command: 00 shut-off, 01 drive-low, 10 drive-high |

## Verification
The bench steps the window duration to exactly one cycle short of the hold-off count. It separates two window stretches by a single-cycle band excursion. A design that fails to restart the counter, or that expires one cycle early, would wrongly shut off there. The bench also checks the exact cycle of shut-off after a long window, so an off-by-one counter or a missing synchronizer stage shows up as a timing mismatch. Band dwell after both high and low commands catches a design that treats the hysteresis band as window or as a level. Contradictory flag sets catch a wrong priority order.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  typedef enum logic [1:0] {
    CMD_OFF  = 2'b00,
    CMD_LOW  = 2'b01,
    CMD_HIGH = 2'b10
  } cmd_e;

  typedef enum logic [1:0] {
    ZN_BAND = 2'b00,
    ZN_LOW  = 2'b01,
    ZN_HIGH = 2'b10,
    ZN_WIN  = 2'b11
  } zone_e;

  localparam int FLAG_W      = 4;
  localparam int F_ABOVE_HI  = 3;
  localparam int F_ABOVE_TOP = 2;
  localparam int F_BELOW_BOT = 1;
  localparam int F_BELOW_LO  = 0;
endpackage

// File: rtl/pwmq_sync.sv
module pwmq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwmq_zone.sv
module pwmq_zone
  import pwmq_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  output zone_e             zone
);
  always_comb begin
    if (flags[F_ABOVE_HI])
      zone = ZN_HIGH;
    else if (flags[F_BELOW_LO])
      zone = ZN_LOW;
    else if (!flags[F_ABOVE_TOP] && !flags[F_BELOW_BOT])
      zone = ZN_WIN;
    else
      zone = ZN_BAND;
  end
endmodule

// File: rtl/pwmq_holdoff.sv
module pwmq_holdoff #(
  parameter int HOLD = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic in_window,
  output logic expired
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  assign expired = in_window && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!in_window)
      cnt <= '0;
    else if (!expired)
      cnt <= cnt + 1'b1;
  end

  AST_CNT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    !in_window |=> cnt == '0);  // R5
  AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (in_window && !expired) |=> cnt == $past(cnt) + 1'b1);  // R4
endmodule

// File: rtl/pwm_tristate_qualifier.sv
module pwm_tristate_qualifier
  import pwmq_pkg::*;
#(
  parameter int HOLD_CYCLES = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       above_high,
  input  logic       above_win_top,
  input  logic       below_win_bot,
  input  logic       below_low,
  output logic [1:0] cmd
);
  logic [FLAG_W-1:0] raw_flags;
  logic [FLAG_W-1:0] sync_flags;
  zone_e             zone;
  logic              expired;
  cmd_e              cmd_q;

  always_comb begin
    raw_flags              = '0;
    raw_flags[F_ABOVE_HI]  = above_high;
    raw_flags[F_ABOVE_TOP] = above_win_top;
    raw_flags[F_BELOW_BOT] = below_win_bot;
    raw_flags[F_BELOW_LO]  = below_low;
  end

  pwmq_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_flags),
    .q   (sync_flags)
  );

  pwmq_zone u_zone (
    .flags (sync_flags),
    .zone  (zone)
  );

  pwmq_holdoff #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .in_window (zone == ZN_WIN),
    .expired   (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_OFF;
    end else begin
      unique case (zone)
        ZN_HIGH: cmd_q <= CMD_HIGH;
        ZN_LOW:  cmd_q <= CMD_LOW;
        ZN_WIN:  if (expired) cmd_q <= CMD_OFF;
        default: cmd_q <= cmd_q;
      endcase
    end
  end

  assign cmd = cmd_q;

  AST_RESET_OFF: assert property (@(posedge clk)
    rst |=> cmd_q == CMD_OFF);  // R1
  AST_HIGH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    zone == ZN_HIGH |=> cmd_q == CMD_HIGH);  // R2
  AST_LOW_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    zone == ZN_LOW |=> cmd_q == CMD_LOW);  // R3
  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    zone == ZN_BAND |=> $stable(cmd_q));  // R6
  AST_OFF_FROM_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cmd_q == CMD_OFF && $past(cmd_q) != CMD_OFF)
      |-> $past(zone == ZN_WIN));  // R4
endmodule

// File: tb/test_pwm_tristate_qualifier.sv
module test_pwm_tristate_qualifier;
  localparam int HOLD = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic above_high = 1'b0, above_win_top = 1'b0, below_win_bot = 1'b0, below_low = 1'b0;
  logic [1:0] cmd;

  always #10 clk = ~clk;

  pwm_tristate_qualifier #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) i_pwm_tristate_qualifier (
    .clk, .rst, .above_high, .above_win_top, .below_win_bot, .below_low, .cmd
  );

  typedef struct {
    logic [1:0] val;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // flag order {above_high, above_win_top, below_win_bot, below_low}
  localparam logic [3:0] F_HIGH = 4'b1100, F_LOW = 4'b0011, F_UBAND = 4'b0100,
                         F_LBAND = 4'b0010, F_WIN = 4'b0000;
  localparam logic [1:0] E_OFF = 2'b00, E_LOW = 2'b01, E_HIGH = 2'b10;

  logic [3:0] ms1, ms2;
  int         mcnt;
  logic [1:0] mcmd;

  // Expected-value model built from R1..R8: two sync stages, then classification.
  task automatic model_edge(input logic [3:0] f, input bit r);
    if (r) begin
      ms1 = '0; ms2 = '0; mcnt = 0; mcmd = E_OFF;
      return;
    end
    if (ms2[3]) begin mcmd = E_HIGH; mcnt = 0; end
    else if (ms2[0]) begin mcmd = E_LOW; mcnt = 0; end
    else if (!ms2[2] && !ms2[1]) begin
      if (mcnt == HOLD - 1) mcmd = E_OFF;
      else mcnt++;
    end else mcnt = 0;
    ms2 = ms1;
    ms1 = f;
  endtask

  task automatic drive(input logic [3:0] f, input int n, input string tag, input bit r = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = r;
      {above_high, above_win_top, below_win_bot, below_low} = f;
      model_edge(f, r);
      q.push_back('{val: mcmd, tag: tag});
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (cmd !== e.val) begin
          n_bad++;
          $display("FAIL %s: cmd=%b expected %b at %0t", e.tag, cmd, e.val, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ms1 = '0; ms2 = '0; mcnt = 0; mcmd = E_OFF;
    drive(F_HIGH, 4, "R1", 1);          // reset state, even with a high level present
    drive(F_UBAND, 25, "R1");           // band after reset keeps shut-off
    drive(F_HIGH, 6, "R2");
    drive(F_UBAND, 12, "R6");           // band holds drive-high
    drive(F_LOW, 6, "R3");
    drive(F_LBAND, 12, "R6");           // band holds drive-low
    drive(F_WIN, HOLD - 1, "R5");       // one cycle short of hold-off
    drive(F_LBAND, 1, "R5");
    drive(F_WIN, HOLD - 1, "R5");
    drive(F_UBAND, 4, "R5");
    drive(F_WIN, HOLD + 6, "R4");       // floating input, exact shut-off cycle
    drive(F_HIGH, 6, "R7");             // exit shut-off to high
    drive(F_WIN, HOLD + 6, "R4");
    drive(F_LBAND, 8, "R6");            // band holds shut-off
    drive(F_LOW, 6, "R7");              // exit shut-off to low
    drive(4'b1111, 6, "R8");            // all flags: high wins
    drive(4'b0111, 6, "R8");            // low wins over window flags
    drive(4'b1001, 6, "R8");            // high wins over low
    drive(4'b0001, 6, "R8");
    drive(F_WIN, 4, "R4");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule